// File: doc/BRIEF.md
# Sleep Control Register with Timed Unlock

This block is the 8-bit sleep control register of a small microcontroller, reached over a simple register bus. The register holds a sleep-enable bit, a three-bit sleep-mode field, two external-interrupt sense bits and a brown-out-off-in-sleep bit. The sense bits are only stored; the logic that uses them lies outside this block. The block decodes the mode field into a one-hot sleep mode. Reserved codes fall back to Idle and raise an illegal-mode flag.

The brown-out-off bit is guarded. Software first writes a signature to a separate protection address. This opens a window of four clock cycles, and a write that sets the bit lands only inside that window. Clearing the bit needs no unlock. A wake event clears the bit as well.

A sleep-instruction strobe enters sleep only while sleep-enable is 1. At that moment the block latches the brown-out-off bit onto its output, and the wake strobe releases it.

Top module: `sleep_ctrl_reg`

## Requirements
- R1: After reset the register reads 0x00, `sleep_active` and `bod_off` are 0, `sleep_mode` is 3'b001 (Idle) and `mode_illegal` is 0.
- R2: A bus write to address 0x3A stores bits 7:6 (interrupt sense), bits 3:1 (mode) and bit 0 (sleep enable). These bits are visible on `bus_rdata` from the next cycle while `bus_addr` is 0x3A. Any other address reads 0x00.
- R3: Bit 5 of the register always reads 0, whatever was written to it.
- R4: Writing 0xD8 to the protection address 0x3C opens an unlock window. A write to 0x3A with bit 4 set, applied 1 to 4 cycles after the signature write, sets bit 4. Applied 5 or more cycles after, or with no signature, it leaves bit 4 unchanged. In both cases the other fields still update.
- R5: The first write to 0x3A closes the window. A write of any other value to 0x3C also closes it.
- R6: A write to 0x3A with bit 4 at 0 clears bit 4 at once, with or without an unlock.
- R7: A `wake_evt` pulse clears bit 4, `sleep_active` and `bod_off` in the next cycle. It takes priority over a write or sleep strobe in the same cycle.
- R8: A `sleep_instr` pulse while bit 0 is 1 and not already sleeping sets `sleep_active` in the next cycle. In the same cycle `bod_off` takes the value of bit 4 as it was when the strobe arrived. While bit 0 is 0 the strobe has no effect on `sleep_active` or `bod_off`.
- R9: `sleep_mode` is one-hot {power-down, ADC noise reduction, Idle}. Mode 000 gives 3'b001, 001 gives 3'b010 and 010 gives 3'b100. Codes 011 through 111 give 3'b001 with `mode_illegal` at 1; otherwise `mode_illegal` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 6 | Register bus address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| sleep_instr | input | 1 | Sleep instruction strobe |
| wake_evt | input | 1 | Wake event strobe |
| sleep_active | output | 1 | Core is asleep |
| sleep_mode | output | 3 | One-hot decoded sleep mode |
| mode_illegal | output | 1 | Reserved mode code selected |
| bod_off | output | 1 | Brown-out detector off during sleep |

## Verification
Register writes, window changes, sleep entry and wake all take effect at the clock edge that samples the strobe. Their results are therefore due one cycle later. Read data and the decoded mode are combinational from the stored state and the current address. The bench drives every input at the falling edge. It checks the outputs of the state at the next falling edge, and it checks read data 1 ns after driving the address, before the rising edge. The unlock window is probed at signature-to-write distances of four and five cycles, which places the checks on both sides of the window's last cycle.

// File: rtl/sleep_ctrl_reg.sv
module sleep_ctrl_reg #(
  parameter int          ADDR_W     = 6,
  parameter logic [5:0]  CTRL_ADDR  = 6'h3A,
  parameter logic [5:0]  PROT_ADDR  = 6'h3C,
  parameter logic [7:0]  SIGNATURE  = 8'hD8,
  parameter int          WIN_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              sleep_instr,
  input  logic              wake_evt,
  output logic              sleep_active,
  output logic [2:0]        sleep_mode,
  output logic              mode_illegal,
  output logic              bod_off
);
  localparam int CNT_W = $clog2(WIN_CYCLES + 1);
  localparam logic [CNT_W-1:0] WIN_LOAD = CNT_W'(WIN_CYCLES);

  logic [7:0]       ctrl_q;
  logic [CNT_W-1:0] win_cnt;
  logic             win_open, ctrl_wr, prot_wr, bods_next;

  assign ctrl_wr  = bus_we && (bus_addr == ADDR_W'(CTRL_ADDR));
  assign prot_wr  = bus_we && (bus_addr == ADDR_W'(PROT_ADDR));
  assign win_open = (win_cnt != '0);

  always_comb begin
    bods_next = ctrl_q[4];
    if (ctrl_wr) begin
      if (!bus_wdata[4])  bods_next = 1'b0;
      else if (win_open)  bods_next = 1'b1;
    end
    if (wake_evt) bods_next = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      win_cnt <= '0;
    end else begin
      if (ctrl_wr) begin
        ctrl_q[7:6] <= bus_wdata[7:6];
        ctrl_q[3:0] <= bus_wdata[3:0];
      end
      ctrl_q[5] <= 1'b0;
      ctrl_q[4] <= bods_next;
      if (prot_wr)       win_cnt <= (bus_wdata == SIGNATURE) ? WIN_LOAD : '0;
      else if (ctrl_wr)  win_cnt <= '0;
      else if (win_open) win_cnt <= win_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sleep_active <= 1'b0;
      bod_off      <= 1'b0;
    end else if (wake_evt) begin
      sleep_active <= 1'b0;
      bod_off      <= 1'b0;
    end else if (sleep_instr && ctrl_q[0] && !sleep_active) begin
      sleep_active <= 1'b1;
      bod_off      <= ctrl_q[4];
    end
  end

  assign bus_rdata = (bus_addr == ADDR_W'(CTRL_ADDR)) ?
                     {ctrl_q[7:6], 1'b0, ctrl_q[4:0]} : 8'h00;

  always_comb begin
    mode_illegal = 1'b0;
    case (ctrl_q[3:1])
      3'b000:  sleep_mode = 3'b001;
      3'b001:  sleep_mode = 3'b010;
      3'b010:  sleep_mode = 3'b100;
      default: begin
        sleep_mode   = 3'b001;
        mode_illegal = 1'b1;
      end
    endcase
  end

  assert_rsvd_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(CTRL_ADDR)) |-> !bus_rdata[5]);

  assert_bods_needs_unlock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q[4]) |-> $past(win_open && ctrl_wr && bus_wdata[4]));

  assert_window_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> !win_open);

  assert_clear_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !bus_wdata[4]) |=> !ctrl_q[4]);

  assert_wake_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |=> (!ctrl_q[4] && !sleep_active && !bod_off));

  assert_bodoff_on_sleep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bod_off) |-> $past(sleep_instr && ctrl_q[0] && ctrl_q[4] && !wake_evt));

  assert_mode_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sleep_mode) == 1);
endmodule

// File: tb/test_sleep_ctrl_reg.sv
module test_sleep_ctrl_reg;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [5:0] A_CTRL = 6'h3A, A_PROT = 6'h3C, A_OTHER = 6'h15;
  localparam logic [7:0] SIG = 8'hD8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0] bus_addr = '0;
  logic bus_we = 1'b0, sleep_instr = 1'b0, wake_evt = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic sleep_active, mode_illegal, bod_off;
  logic [2:0] sleep_mode;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [7:0] m_reg = '0;
  int         m_cnt = 0;
  logic       m_sleep = 0, m_boff = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sleep_ctrl_reg i_sleep_ctrl_reg (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sleep_instr(sleep_instr),
    .wake_evt(wake_evt), .sleep_active(sleep_active), .sleep_mode(sleep_mode),
    .mode_illegal(mode_illegal), .bod_off(bod_off));

  function automatic logic [2:0] exp_mode(input logic [2:0] sm);
    case (sm)
      3'b001:  return 3'b010;
      3'b010:  return 3'b100;
      default: return 3'b001;
    endcase
  endfunction

  function automatic logic exp_illegal(input logic [2:0] sm);
    return sm > 3'b010;
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%02h expected 0x%02h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step(input logic [5:0] a, input logic w, input logic [7:0] d,
                      input logic si, input logic wk,
                      input int exp_rd = -1, input string tag = "");
    logic [7:0] n_reg;
    int         n_cnt;
    logic       n_sleep, n_boff, cw, pw;
    @(negedge clk);
    chk("R9 sleep_mode", {5'b0, sleep_mode}, {5'b0, exp_mode(m_reg[3:1])});
    chk("R9 mode_illegal", {7'b0, mode_illegal}, {7'b0, exp_illegal(m_reg[3:1])});
    chk("R8 sleep_active", {7'b0, sleep_active}, {7'b0, m_sleep});
    chk("R8 bod_off", {7'b0, bod_off}, {7'b0, m_boff});
    bus_addr = a; bus_we = w; bus_wdata = d; sleep_instr = si; wake_evt = wk;
    #1;
    chk("R2 read data", bus_rdata, (a == A_CTRL) ? m_reg : 8'h00);
    if (exp_rd >= 0) chk(tag, bus_rdata, 8'(exp_rd));
    cw = w && (a == A_CTRL);
    pw = w && (a == A_PROT);
    n_reg = m_reg;
    if (cw) begin
      n_reg = {d[7:6], 1'b0, m_reg[4], d[3:0]};
      if (!d[4])          n_reg[4] = 1'b0;
      else if (m_cnt > 0) n_reg[4] = 1'b1;
    end
    if (wk) n_reg[4] = 1'b0;
    n_cnt = pw ? ((d == SIG) ? 4 : 0) : cw ? 0 : (m_cnt > 0 ? m_cnt - 1 : 0);
    n_sleep = m_sleep; n_boff = m_boff;
    if (wk) begin n_sleep = 0; n_boff = 0; end
    else if (si && m_reg[0] && !m_sleep) begin n_sleep = 1; n_boff = m_reg[4]; end
    @(posedge clk);
    m_reg = n_reg; m_cnt = n_cnt; m_sleep = n_sleep; m_boff = n_boff;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(A_OTHER, 0, 0, 0, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    step(A_CTRL, 0, 0, 0, 0, 8'h00, "R1 reset read");
    chk("R1 bod_off after reset", {7'b0, bod_off}, 8'h00);
    chk("R1 sleep_mode after reset", {5'b0, sleep_mode}, 8'h01);

    step(A_CTRL, 1, 8'hFF, 0, 0);
    step(A_CTRL, 0, 0, 0, 0, 8'hCF, "R4 locked set, R3 bit5 zero");
    step(A_OTHER, 0, 0, 0, 0, 8'h00, "R2 other address");

    step(A_PROT, 1, SIG, 0, 0);
    idle(3);
    step(A_CTRL, 1, 8'h14, 0, 0);
    step(A_CTRL, 0, 0, 0, 0, 8'h14, "R4 set at window edge");

    step(A_CTRL, 1, 8'h04, 0, 0);
    step(A_CTRL, 0, 0, 0, 0, 8'h04, "R6 free clear");

    step(A_PROT, 1, SIG, 0, 0);
    idle(4);
    step(A_CTRL, 1, 8'h52, 0, 0);
    step(A_CTRL, 0, 0, 0, 0, 8'h42, "R4 window expired");

    step(A_PROT, 1, SIG, 0, 0);
    step(A_CTRL, 1, 8'h00, 0, 0);
    step(A_CTRL, 1, 8'h10, 0, 0);
    step(A_CTRL, 0, 0, 0, 0, 8'h00, "R5 closed after first write");

    step(A_PROT, 1, 8'hD9, 0, 0);
    step(A_CTRL, 1, 8'h10, 0, 0);
    step(A_CTRL, 0, 0, 0, 0, 8'h00, "R5 wrong signature");

    step(A_CTRL, 1, 8'h04, 0, 0);
    step(A_OTHER, 0, 0, 1, 0);
    step(A_CTRL, 0, 0, 0, 0, 8'h04, "R8 sleep ignored without enable");
    chk("R8 no sleep without enable", {7'b0, sleep_active}, 8'h00);

    step(A_PROT, 1, SIG, 0, 0);
    step(A_CTRL, 1, 8'h15, 0, 0);
    step(A_OTHER, 0, 0, 1, 0);
    step(A_OTHER, 0, 0, 0, 0);
    chk("R8 bod_off latched", {7'b0, bod_off}, 8'h01);
    chk("R9 power-down decode", {5'b0, sleep_mode}, 8'h04);
    step(A_OTHER, 0, 0, 0, 1);
    step(A_CTRL, 0, 0, 0, 0, 8'h05, "R7 wake clears bit4");
    chk("R7 bod_off released", {7'b0, bod_off}, 8'h00);

    for (int sm = 0; sm < 8; sm++) begin
      step(A_CTRL, 1, 8'(sm << 1), 0, 0);
      step(A_OTHER, 0, 0, 0, 0);
      chk("R9 illegal flag", {7'b0, mode_illegal}, {7'b0, sm > 2});
    end

    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 9);
      logic [5:0] a = (r < 4) ? A_CTRL : (r < 7) ? A_PROT : 6'($urandom);
      logic [7:0] d = ($urandom_range(0, 2) == 0) ? SIG : 8'($urandom);
      step(a, $urandom_range(0, 2) != 0, d,
           $urandom_range(0, 5) == 0, $urandom_range(0, 7) == 0);
    end
    idle(2);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule